// File: doc/BRIEF.md
# Unconditional Jump Target Unit

This block sits beside the instruction fetch path of an 8-bit microcontroller core and works out where execution goes after an unconditional jump. Instruction bytes arrive one at a time with a valid flag. For each opcode byte the fetch side also supplies the address of that opcode. The core supplies the accumulator and the 16-bit data pointer.

Three jumps are recognised. The indirect jump is one byte, and its target is the accumulator plus the data pointer. The absolute jump is two bytes and stays inside a 2K page. Its target takes three bits from the opcode and eight bits from the operand. The top five bits come from the address of the instruction that follows the jump, so a jump that sits at the very end of a page lands in the next page. The long jump is three bytes and carries a full 16-bit target, high byte first. When a jump has all of its bytes, the unit gives a one-cycle target strobe together with the new program counter. Any other opcode gives a one-cycle "not a branch" pulse, and the core then advances the PC normally. While operand bytes are still due, the unit reports busy and does not decode them as opcodes.

Top module: `jmp_target_unit`

## Requirements
- R1: After reset, `tgt_valid_o`, `not_branch_o` and `busy_o` are 0 and `tgt_pc_o` is 0x0000.
- R2: An accepted opcode 0x73 while idle gives `tgt_valid_o`=1 on the next cycle. `tgt_pc_o` is then (zero-extended `acc_i` + `dptr_i`) mod 2^16, using the values present with the opcode.
- R3: Any opcode byte whose low five bits are 0_0001 (all eight values 0x01, 0x21, ..., 0xE1) is an absolute jump. On the cycle after its operand byte is accepted, `tgt_valid_o`=1, `tgt_pc_o[10:8]` = opcode bits 7:5, and `tgt_pc_o[7:0]` = the operand byte.
- R4: For an absolute jump, `tgt_pc_o[15:11]` = bits 15:11 of (opcode address + 2) mod 2^16. An opcode at 0x07FE therefore targets page 0x0800.
- R5: Opcode 0x02 is a long jump. The next accepted byte is the target high byte and the one after it is the low byte. On the cycle after the low byte, `tgt_valid_o`=1 and `tgt_pc_o` = {high, low}.
- R6: Each completed jump raises `tgt_valid_o` for exactly one cycle.
- R7: While operand bytes are still due, `busy_o`=1, and accepted bytes are treated as operands, never as opcodes. This holds even when they equal 0x73, 0x02 or xxx0_0001.
- R8: Any other accepted opcode gives `not_branch_o`=1 for one cycle, with no target strobe. `not_branch_o` and `tgt_valid_o` are never high together.
- R9: Cycles with `byte_valid_i`=0 change no state. Gaps of any length may separate the bytes of one instruction.
- R10: `tgt_pc_o` changes only when `tgt_valid_o` rises with a new target. Otherwise it holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_valid_i | input | 1 | `byte_i` carries an instruction byte this cycle |
| byte_i | input | 8 | Opcode or operand byte |
| pc_i | input | 16 | Address of the opcode byte; sampled only with an opcode |
| acc_i | input | 8 | Accumulator value |
| dptr_i | input | 16 | Data pointer value |
| tgt_valid_o | output | 1 | One-cycle strobe: load `tgt_pc_o` into the PC |
| tgt_pc_o | output | 16 | Jump target |
| not_branch_o | output | 1 | One-cycle pulse: the last opcode was not a jump |
| busy_o | output | 1 | Operand bytes still due |

## Verification
The assertions assume that fetch presents only whole instructions, so every opcode is followed by its full operand count before the stream ends. They also assume that `acc_i`, `dptr_i` and `pc_i` are meaningful in the cycle an opcode is accepted. The stimulus gives every instruction all of its operands, though sometimes with idle gaps in between. It changes the accumulator, data pointer and PC freely while operands are pending, which shows that they are sampled only with the opcode. The directed cases cover page-edge absolute jumps, data pointer wraparound, back-to-back indirect jumps and operands that look like opcodes. A random stream of whole instructions follows.

// File: rtl/jtu_pkg.sv
package jtu_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ABS_LO, ST_LONG_HI, ST_LONG_LO} jtu_state_e;
  typedef enum logic [1:0] {K_OTHER, K_IND, K_ABS, K_LONG} jtu_kind_e;

  localparam logic [7:0] OP_IND    = 8'h73;
  localparam logic [7:0] OP_LONG   = 8'h02;
  localparam logic [4:0] ABS_LOW5  = 5'b0_0001;
endpackage

// File: rtl/jtu_decode.sv
module jtu_decode
  import jtu_pkg::*;
(
  input  logic [7:0] op_i,
  output jtu_kind_e  kind_o
);
  always_comb begin
    if (op_i == OP_IND)              kind_o = K_IND;
    else if (op_i == OP_LONG)        kind_o = K_LONG;
    else if (op_i[4:0] == ABS_LOW5)  kind_o = K_ABS;
    else                             kind_o = K_OTHER;
  end
endmodule

// File: rtl/jtu_addr.sv
module jtu_addr #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 11
) (
  input  logic [DATA_W-1:0]        acc_i,
  input  logic [ADDR_W-1:0]        dptr_i,
  input  logic [ADDR_W-1:0]        pc_i,
  output logic [ADDR_W-1:0]        ind_tgt_o,
  output logic [ADDR_W-PAGE_W-1:0] page_o
);
  localparam int EXT_W = ADDR_W - DATA_W;
  logic [ADDR_W-1:0] next_pc;

  // wraps mod 2^ADDR_W
  assign ind_tgt_o = {{EXT_W{1'b0}}, acc_i} + dptr_i;
  // page of the following instruction, not of the opcode itself
  assign next_pc   = pc_i + ADDR_W'(2);
  assign page_o    = next_pc[ADDR_W-1:PAGE_W];
endmodule

// File: rtl/jmp_target_unit.sv
module jmp_target_unit
  import jtu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_valid_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [ADDR_W-1:0] dptr_i,
  output logic              tgt_valid_o,
  output logic [ADDR_W-1:0] tgt_pc_o,
  output logic              not_branch_o,
  output logic              busy_o
);
  localparam int SEL_W  = 3;
  localparam int PAGE_W = DATA_W + SEL_W;
  localparam int HI_W   = ADDR_W - DATA_W;

  jtu_state_e             state_q;
  jtu_kind_e              kind;
  logic [HI_W-1:0]        hi_q;
  logic [ADDR_W-1:0]      ind_tgt;
  logic [ADDR_W-PAGE_W-1:0] page;
  logic                   op_take;

  jtu_decode u_dec (.op_i(byte_i), .kind_o(kind));

  jtu_addr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_addr (
    .acc_i    (acc_i),
    .dptr_i   (dptr_i),
    .pc_i     (pc_i),
    .ind_tgt_o(ind_tgt),
    .page_o   (page)
  );

  assign op_take = byte_valid_i && (state_q == ST_IDLE);
  assign busy_o  = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      hi_q         <= '0;
      tgt_pc_o     <= '0;
      tgt_valid_o  <= 1'b0;
      not_branch_o <= 1'b0;
    end else begin
      tgt_valid_o  <= 1'b0;
      not_branch_o <= 1'b0;
      if (byte_valid_i) begin
        unique case (state_q)
          ST_IDLE: begin
            unique case (kind)
              K_IND: begin
                tgt_pc_o    <= ind_tgt;
                tgt_valid_o <= 1'b1;
              end
              K_ABS: begin
                hi_q    <= {page, byte_i[DATA_W-1 -: SEL_W]};
                state_q <= ST_ABS_LO;
              end
              K_LONG:  state_q <= ST_LONG_HI;
              default: not_branch_o <= 1'b1;
            endcase
          end
          ST_LONG_HI: begin
            hi_q    <= byte_i[HI_W-1:0];
            state_q <= ST_LONG_LO;
          end
          default: begin  // ST_ABS_LO, ST_LONG_LO: last operand
            tgt_pc_o    <= {hi_q, byte_i};
            tgt_valid_o <= 1'b1;
            state_q     <= ST_IDLE;
          end
        endcase
      end
    end
  end

  // R2
  ind_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_take && (byte_i == OP_IND) |=>
      tgt_valid_o && (tgt_pc_o == $past(ADDR_W'(acc_i) + dptr_i)));

  // R3
  abs_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_i && (state_q == ST_ABS_LO) |=>
      tgt_valid_o && (tgt_pc_o[DATA_W-1:0] == $past(byte_i)));

  // R7
  operand_not_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_i && busy_o |=> !not_branch_o);

  // R8
  excl_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tgt_valid_o && not_branch_o));

  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_valid_i |=> !tgt_valid_o && !not_branch_o && $stable(state_q));

  // R10
  tgt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tgt_valid_o |-> $stable(tgt_pc_o));
endmodule

// File: tb/tb_jmp_target_unit.sv
`timescale 1ns/1ps
module tb_jmp_target_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bv = 1'b0;
  logic [7:0]  b = '0;
  logic [15:0] pc = '0;
  logic [7:0]  acc = '0;
  logic [15:0] dptr = '0;
  logic        tv, nb, busy;
  logic [15:0] tpc;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  jmp_target_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .byte_valid_i(bv), .byte_i(b),
    .pc_i(pc), .acc_i(acc), .dptr_i(dptr),
    .tgt_valid_o(tv), .tgt_pc_o(tpc), .not_branch_o(nb), .busy_o(busy));

  // behavioural reference: pending operand count and collected bytes
  int m_need = 0, m_kind = 0;    // kind: 1 abs, 2 long
  int m_hi = 0, m_pc = 0;
  bit m_tv = 0, m_nb = 0;
  string m_tag = "R10";
  bit m_cross = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_need = 0; m_tv = 0; m_nb = 0; m_pc = 0; m_tag = "R1";
    end else begin
      m_tv = 0; m_nb = 0;
      if (bv) begin
        if (m_need == 0) begin
          if (b == 8'h73) begin
            m_pc = (acc + dptr) % 65536; m_tv = 1; m_tag = "R2";
          end else if (b == 8'h02) begin
            m_kind = 2; m_need = 2;
          end else if ((b & 8'h1F) == 8'h01) begin
            m_kind = 1; m_need = 1;
            m_cross = (((pc + 2) % 65536) >> 11) != (pc >> 11);
            m_hi = ((((pc + 2) % 65536) >> 11) << 3) | (b >> 5);
          end else m_nb = 1;
        end else if (m_kind == 2 && m_need == 2) begin
          m_hi = b; m_need = 1;
        end else begin
          m_pc = m_hi * 256 + b; m_tv = 1; m_need = 0;
          m_tag = (m_kind == 2) ? "R5" : (m_cross ? "R4" : "R3");
        end
      end
    end
    #1;
    chk(tv == m_tv, "R6", tv, m_tv);
    chk(nb == m_nb, "R8", nb, m_nb);
    chk(busy == (m_need != 0), "R7", busy, m_need != 0);
    chk(tpc == m_pc[15:0], m_tv ? m_tag : (rst_n ? "R10" : "R1"), tpc, m_pc);
  end

  task automatic put(input logic [7:0] v, input logic [15:0] a = 16'h0);
    @(negedge clk);
    bv = 1'b1; b = v; pc = a;
    @(negedge clk);
    bv = 1'b0; b = $urandom; pc = $urandom;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #40000000;
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    // R1 reset state
    chk(tv == 0 && nb == 0 && busy == 0 && tpc == 0, "R1", {tv, nb, busy}, 0);
    @(negedge clk) rst_n = 1'b1;
    idle(2);
    // R2 indirect, including wraparound
    acc = 8'h10; dptr = 16'h1234; put(8'h73);
    acc = 8'hFF; dptr = 16'hFFF0; put(8'h73);
    // back-to-back indirect
    @(negedge clk); bv = 1; b = 8'h73; acc = 8'h01; dptr = 16'h0100;
    @(negedge clk); acc = 8'h02;
    @(negedge clk); bv = 0;
    // R3 all eight absolute variants
    for (int i = 0; i < 8; i++) begin
      put(8'(i * 32 + 1), 16'h4A10);
      acc = $urandom; dptr = $urandom;
      put(8'h5C);
    end
    // R4 page edge
    put(8'h41, 16'h07FE); put(8'hFF);
    put(8'hE1, 16'h07FD); put(8'h00);
    put(8'h21, 16'hFFFF); put(8'h33);
    // R5 long with gaps, R7 operands resembling opcodes
    put(8'h02); idle(3); put(8'h73); idle(2); put(8'h02);
    put(8'h02); put(8'h01); put(8'hE1);
    put(8'h21, 16'h1000); put(8'h73);
    // R8 non-branches
    put(8'h00); put(8'hFF); put(8'h12); put(8'hE4); put(8'h03);
    // R9 long idle, R10 hold
    idle(20);
    // random whole instructions
    for (int n = 0; n < 400; n++) begin
      logic [7:0] op;
      op = $urandom;
      case ($urandom % 4)
        0: op = 8'h73;
        1: op = 8'h02;
        2: op = {op[7:5], 5'b00001};
        default: ;
      endcase
      acc = $urandom; dptr = $urandom;
      put(op, 16'($urandom));
      if (op == 8'h02) begin idle($urandom % 3); put($urandom); end
      if (op == 8'h02 || op[4:0] == 5'b00001) begin idle($urandom % 3); put($urandom); end
      idle($urandom % 2);
    end
    idle(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule